// File: doc/BRIEF.md
# CAN Bus-Off Recovery Controller

This block decides when a CAN node that has gone bus-off may return to error-active. It watches the stream of sampled receive bits, counts runs of consecutive recessive bits and, once the required number of runs has been seen, releases the node from bus-off. Counting starts afresh on every bus-off entry pulse from the error-counter logic.

Two recovery policies are offered, picked by a policy input. With the policy bit low (the value to use after reset), the completed count alone ends bus-off. With the policy bit high, a hold flag also has to be cleared by software. The hold flag is raised on every bus-off entry. The hold flag and the completed count are latched independently, so either one may come first. On recovery the block drops its bus-off status, clears its counters and its hold flag, and emits a one-cycle pulse.

Top module: `canbo_recovery`

## Requirements
- R1: After reset the bus-off status, the hold flag and the recovery-done pulse are all low.
- R2: A cycle with `busoff_enter` high sets both the bus-off status and the hold flag on the following clock edge.
- R3: While bus-off, a strobed bit with `rx_bit` = 1 (recessive) extends the current run. Once `RUN_LEN` (11) of them follow one another, one occurrence is counted and the run restarts. Cycles with `bit_strobe` low leave the run unchanged, whatever `rx_bit` holds.
- R4: A strobed bit with `rx_bit` = 0 (dominant) restarts the current run from zero but keeps the occurrences already counted.
- R5: With `user_mode` = 0, bus-off ends on the clock edge after the edge that completes occurrence number `OCC_TARGET` (128), whatever the state of the hold flag.
- R6: With `user_mode` = 1, bus-off ends only when the count is complete and the hold flag is low, in either order. It ends on the edge after the later of the two.
- R7: A cycle with `hold_clear` high clears the hold flag on the next edge. If `busoff_enter` is high in the same cycle, the entry wins and the flag is set.
- R8: The occurrence count saturates at `OCC_TARGET` and stays complete, over further runs, until recovery takes place.
- R9: `recover_done` is high for exactly one cycle, in the first cycle in which bus-off reads low. Recovery clears both counters and the hold flag, so the next bus-off again needs the full count.
- R10: A `busoff_enter` pulse in the cycle in which recovery would take place keeps the node bus-off, gives no done pulse and restarts counting from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_strobe | input | 1 | One-cycle strobe marking a sampled bus bit |
| rx_bit | input | 1 | Sampled bus bit, 1 = recessive, 0 = dominant |
| busoff_enter | input | 1 | One-cycle pulse: the node has just gone bus-off |
| user_mode | input | 1 | Recovery policy, 0 = automatic, 1 = user request |
| hold_clear | input | 1 | Software write-one strobe that clears the hold flag |
| busoff | output | 1 | Node is in the bus-off state |
| hold | output | 1 | Hold flag still blocks user-request recovery |
| recover_done | output | 1 | One-cycle pulse on return to error-active |

## Verification
Two functions can fall in the same cycle and must be resolved. The first pair is bus-off entry and recovery. The bench completes the 128th run and, in the very cycle the recovery condition becomes true, drives a new entry pulse. It then expects bus-off still set, no done pulse, and a full new count needed before release. The second pair is entry and the hold-clear write, driven together; the bench judges it by the hold flag still reading high afterwards.

// File: rtl/canbo_pkg.sv
package canbo_pkg;

    typedef struct packed {
        logic busoff;
        logic hold;
        logic done;
    } ctl_state_t;

endpackage

// File: rtl/canbo_run_cnt.sv
module canbo_run_cnt #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    input  logic strobe,
    input  logic rx_bit,
    output logic run_done
);
    localparam int W = $clog2(RUN_LEN + 1);

    logic [W-1:0] run_d, run_q;

    always_comb begin
        run_done = enable && strobe && rx_bit && (run_q == W'(RUN_LEN - 1));
        run_d    = run_q;
        if (clear) begin
            run_d = '0;
        end else if (enable && strobe) begin
            if (!rx_bit || run_done) run_d = '0;
            else                     run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assert_run_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < W'(RUN_LEN));

    assert_gap_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !clear) |=> $stable(run_q));

    assert_dominant_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && strobe && !rx_bit) |=> (run_q == '0));

endmodule

// File: rtl/canbo_occ_cnt.sv
module canbo_occ_cnt #(
    parameter int OCC_TARGET = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic full
);
    localparam int W = $clog2(OCC_TARGET + 1);

    logic [W-1:0] occ_d, occ_q;

    always_comb begin
        full  = (occ_q == W'(OCC_TARGET));
        occ_d = occ_q;
        if (clear)             occ_d = '0;
        else if (inc && !full) occ_d = occ_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end

    assert_occ_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= W'(OCC_TARGET));

    assert_occ_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !inc) |=> $stable(occ_q));

    assert_full_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clear) |=> full);

endmodule

// File: rtl/canbo_recovery.sv
module canbo_recovery #(
    parameter int RUN_LEN    = 11,
    parameter int OCC_TARGET = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_strobe,
    input  logic rx_bit,
    input  logic busoff_enter,
    input  logic user_mode,
    input  logic hold_clear,
    output logic busoff,
    output logic hold,
    output logic recover_done
);
    import canbo_pkg::*;

    ctl_state_t st_d, st_q;
    logic run_done, count_full, recover_ok, cnt_clear;

    canbo_run_cnt #(.RUN_LEN(RUN_LEN)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .enable   (st_q.busoff),
        .strobe   (bit_strobe),
        .rx_bit   (rx_bit),
        .run_done (run_done)
    );

    canbo_occ_cnt #(.OCC_TARGET(OCC_TARGET)) u_occ (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .inc   (run_done),
        .full  (count_full)
    );

    always_comb begin
        recover_ok = st_q.busoff && count_full && (!user_mode || !st_q.hold)
                     && !busoff_enter;
        cnt_clear  = busoff_enter || recover_ok;

        st_d      = st_q;
        st_d.done = 1'b0;
        if (busoff_enter) begin
            st_d.busoff = 1'b1;
            st_d.hold   = 1'b1;
        end else begin
            if (hold_clear) st_d.hold = 1'b0;
            if (recover_ok) begin
                st_d.busoff = 1'b0;
                st_d.hold   = 1'b0;
                st_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busoff       = st_q.busoff;
    assign hold         = st_q.hold;
    assign recover_done = st_q.done;

    assert_entry_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_enter |=> (busoff && hold));

    assert_leave_needs_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busoff) |-> (recover_done && $past(count_full)));

    assert_user_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (recover_done && $past(user_mode)) |-> !$past(hold));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        recover_done |=> !recover_done);

    assert_done_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        recover_done |-> (!busoff && $past(busoff)));

    assert_entry_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_enter |=> !recover_done);

endmodule

// File: tb/canbo_recovery_test.sv
module canbo_recovery_test;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_LEN    = 11;
    localparam int OCC_TARGET = 128;

    // {user_mode, clear hold early, glitch in count, expect release at count}
    localparam logic [3:0] SCN [0:4] = '{4'b0001, 4'b0011, 4'b1000, 4'b1101, 4'b1111};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_strobe = 1'b0, rx_bit = 1'b1, busoff_enter = 1'b0;
    logic user_mode = 1'b0, hold_clear = 1'b0;
    logic busoff, hold, recover_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    canbo_recovery #(.RUN_LEN(RUN_LEN), .OCC_TARGET(OCC_TARGET)) uut (
        .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .rx_bit(rx_bit),
        .busoff_enter(busoff_enter), .user_mode(user_mode), .hold_clear(hold_clear),
        .busoff(busoff), .hold(hold), .recover_done(recover_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic tick_idle();
        @(negedge clk);
        bit_strobe = 1'b0; rx_bit = 1'b1; busoff_enter = 1'b0; hold_clear = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_strobe = 1'b1; rx_bit = b; busoff_enter = 1'b0; hold_clear = 1'b0;
    endtask

    task automatic gap_dominant();
        @(negedge clk);
        bit_strobe = 1'b0; rx_bit = 1'b0; busoff_enter = 1'b0; hold_clear = 1'b0;
    endtask

    task automatic send_runs(input int n);
        for (int r = 0; r < n; r++)
            for (int b = 0; b < RUN_LEN; b++) send_bit(1'b1);
    endtask

    task automatic pulse_enter();
        @(negedge clk);
        bit_strobe = 1'b0; busoff_enter = 1'b1; hold_clear = 1'b0;
        tick_idle();
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        bit_strobe = 1'b0; busoff_enter = 1'b0; hold_clear = 1'b1;
    endtask

    // Feeds OCC_TARGET-1 runs plus RUN_LEN-1 bits, checks still bus-off,
    // then the last bit and two idle cycles.
    task automatic feed_count(input logic glitch);
        for (int r = 0; r < OCC_TARGET - 1; r++) begin
            if (glitch && r == 30) begin
                for (int b = 0; b < 5; b++) send_bit(1'b1);
                gap_dominant(); gap_dominant();          // R3: no strobe, ignored
                for (int b = 0; b < RUN_LEN - 5; b++) send_bit(1'b1);
            end else if (glitch && r == 60) begin
                for (int b = 0; b < 7; b++) send_bit(1'b1);
                send_bit(1'b0);                          // R4: run broken
                send_runs(1);
            end else begin
                send_runs(1);
            end
        end
        for (int b = 0; b < RUN_LEN - 1; b++) send_bit(1'b1);
        tick_idle(); tick_idle();
        chk("R4 one bit short keeps bus-off", busoff, 1'b1);
        send_bit(1'b1);
        tick_idle(); tick_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick_idle();
        chk("R1 busoff after reset", busoff, 1'b0);
        chk("R1 hold after reset", hold, 1'b0);
        chk("R1 done after reset", recover_done, 1'b0);

        // Table of scenarios walked by one loop
        for (int i = 0; i < 5; i++) begin
            logic [3:0] v;
            v = SCN[i];
            user_mode = v[3];
            pulse_enter();
            chk("R2 busoff on entry", busoff, 1'b1);
            chk("R2 hold on entry", hold, 1'b1);
            if (v[2]) begin
                pulse_clear(); tick_idle();
                chk("R7 hold cleared by write", hold, 1'b0);
            end
            feed_count(v[1]);
            if (v[0]) begin
                chk(v[3] ? "R6 release clear-first" : "R5 auto release", busoff, 1'b0);
                chk("R9 done pulse", recover_done, 1'b1);
                tick_idle();
                chk("R9 done one cycle", recover_done, 1'b0);
                chk("R9 hold cleared on recovery", hold, 1'b0);
            end else begin
                chk("R6 hold blocks release", busoff, 1'b1);
                chk("R6 no done while held", recover_done, 1'b0);
                send_runs(3);
                tick_idle(); tick_idle();
                chk("R8 saturated still held", busoff, 1'b1);
                pulse_clear(); tick_idle(); tick_idle();
                chk("R8 release after late clear", busoff, 1'b0);
                chk("R6 done after late clear", recover_done, 1'b1);
                tick_idle();
                chk("R9 done one cycle", recover_done, 1'b0);
            end
        end

        // R10: entry in the cycle recovery would occur
        user_mode = 1'b0;
        pulse_enter();
        send_runs(OCC_TARGET);
        @(negedge clk);
        bit_strobe = 1'b0; busoff_enter = 1'b1;
        tick_idle();
        chk("R10 stays bus-off", busoff, 1'b1);
        chk("R10 no done pulse", recover_done, 1'b0);
        chk("R10 hold set", hold, 1'b1);
        feed_count(1'b0);
        chk("R10 recovery after fresh count", busoff, 1'b0);
        chk("R10 done after fresh count", recover_done, 1'b1);
        tick_idle();

        // R7: entry and hold clear together; clear alone does not release
        user_mode = 1'b1;
        @(negedge clk);
        busoff_enter = 1'b1; hold_clear = 1'b1;
        tick_idle();
        chk("R7 entry wins over clear", hold, 1'b1);
        pulse_clear(); tick_idle(); tick_idle();
        chk("R7 hold cleared", hold, 1'b0);
        chk("R6 clear alone keeps bus-off", busoff, 1'b1);
        feed_count(1'b0);
        chk("R9 full count needed again", busoff, 1'b0);
        chk("R9 done after count", recover_done, 1'b1);
        tick_idle();

        summary();
    end
endmodule